// File: doc/BRIEF.md
# OTP configuration programming sequencer

This block runs on the host side. It burns a 16-bit configuration word into the one-time-programmable fuse register of an angle sensor over a three-wire link: an active-low select line `csN`, a serial clock `sClk` and a program data line `progData`. It also drives an enable, `vprogEn`, for the external transistor that switches the program line up to the fusing voltage.

A single `start` strobe begins the sequence. The block first latches the configuration fields and the timing settings. It opens programming mode by raising `csN` while `progData` is held high. It then shifts the word out MSB first, changing data only on falling clock edges. Next it switches the program line over to high voltage. After a programmable settling time it issues a fixed burst of 16 fuse-burn clock pulses. When the burst ends it removes the high voltage and raises `done`.

The target leaves programming mode only through its own power-on reset. For that reason the block also locks once it is done: it ignores further starts until the block itself is reset. The clock half period is `halfPeriod` system cycles; a value of zero counts as one.

Top module: `otp_prog_seq`

## Requirements
- R1: Out of reset, and while idle, `csN`, `sClk`, `progData`, `vprogEn`, `busy` and `done` are all 0.
- R2: The shifted word is bit 15 = `cfgCcw`, bits 14..5 = `cfgZero[9:0]`, bit 4 = `cfgGainInt`, bit 3 = `cfgRefExt`, bit 2 = `cfgClamp`, bits 1..0 = `cfgRange[1:0]`. It is sent from bit 15 down to bit 0.
- R3: In the cycle after `start` is sampled, `progData` goes to 1 with `csN` still 0, for H cycles. `csN` then rises and stays 1 while `progData` stays 1 for another H cycles. H is `halfPeriod`, or 1 when `halfPeriod` is 0.
- R4: Each of the 16 bits is held for a low clock phase of H cycles followed by a high phase of H cycles. `progData` changes only in the cycle where `sClk` falls.
- R5: After the 16th high phase, `vprogEn` goes to 1 with `progData` 0 and `sClk` 0, and this lasts `settleCycles`+1 cycles.
- R6: Exactly 16 burn pulses follow, each H cycles low then H cycles high, with `vprogEn` 1 and `progData` 0 throughout.
- R7: After the 16th burn pulse, `vprogEn` and `sClk` are 0, `csN` stays 1, `done` is 1 and `busy` is 0. This state holds until reset.
- R8: `busy` is 1 from the cycle after `start` until the cycle in which `done` rises.
- R9: A `start` while busy or done has no effect. Changes to the configuration and timing inputs after `start` do not alter the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin programming (sampled when idle) |
| cfgCcw | input | 1 | Rotation-direction bit |
| cfgZero | input | 10 | Zero position |
| cfgGainInt | input | 1 | Output amplifier gain select |
| cfgRefExt | input | 1 | Converter reference select |
| cfgClamp | input | 1 | Output span clamp mode |
| cfgRange | input | 2 | Output angular range select |
| halfPeriod | input | DIV_W | Serial clock half period in system cycles |
| settleCycles | input | SETTLE_W | High-voltage settling delay minus one |
| csN | output | 1 | Select line to the target |
| sClk | output | 1 | Serial clock to the target |
| progData | output | 1 | Program data line |
| vprogEn | output | 1 | Enable for the external fusing-voltage switch |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Programming finished (held until reset) |

## Verification
Every output is decoded from registers, so each output responds one system cycle after the `start` edge. From that cycle on, the whole waveform is a closed function of the cycle count t, the effective half period H and the settle length S. Over t the phases are: the open phases (t < 2H), the bit phases up to 34H, the settle window up to 34H+S+1, the burn phases up to 66H+S+1, and then the final state. The bench computes that function arithmetically and compares all six outputs on the falling clock edge of every cycle. A sweep over several half periods, settle lengths and word patterns drives this, with a restart and input changes injected mid-run and after the end.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;

  localparam int WORD_W = 16;
  localparam int ZERO_W = 10;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_OPEN,
    ST_SLO,
    ST_SHI,
    ST_SETTLE,
    ST_BLO,
    ST_BHI,
    ST_DONE
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic phaseRun;
    logic shift;
    logic settleRun;
    logic pulseInc;
  } seqCmd_t;

endpackage

// File: rtl/otp_prog_dp.sv
module otp_prog_dp
  import otp_prog_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int SETTLE_W = 12,
  parameter int BURN_PULSES = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqCmd_t             cmd,
  input  logic [WORD_W-1:0]   cfgWord,
  input  logic [DIV_W-1:0]    halfPeriod,
  input  logic [SETTLE_W-1:0] settleCycles,
  output logic                phaseEnd,
  output logic                lastBit,
  output logic                settleEnd,
  output logic                lastPulse,
  output logic                dataBit
);

  localparam int BIT_W   = $clog2(WORD_W);
  localparam int PULSE_W = (BURN_PULSES > 1) ? $clog2(BURN_PULSES) : 1;

  logic [WORD_W-1:0]   wordReg;
  logic [DIV_W-1:0]    halfLat;
  logic [SETTLE_W-1:0] settleLat;
  logic [DIV_W-1:0]    phaseCnt;
  logic [BIT_W-1:0]    bitCnt;
  logic [PULSE_W-1:0]  pulseCnt;
  logic [SETTLE_W-1:0] settleCnt;

  // Latched settings and word
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordReg   <= '0;
      halfLat   <= DIV_W'(1);
      settleLat <= '0;
    end else if (cmd.load) begin
      wordReg   <= cfgWord;
      halfLat   <= (halfPeriod == '0) ? DIV_W'(1) : halfPeriod;
      settleLat <= settleCycles;
    end else if (cmd.shift) begin
      wordReg   <= {wordReg[WORD_W-2:0], 1'b0};
    end
  end

  // Half-period timebase
  always_ff @(posedge clk) begin
    if (!rstN || !cmd.phaseRun) phaseCnt <= '0;
    else if (phaseEnd)          phaseCnt <= '0;
    else                        phaseCnt <= phaseCnt + 1'b1;
  end

  // Bit and burn-pulse counters
  always_ff @(posedge clk) begin
    if (!rstN || cmd.load) begin
      bitCnt   <= '0;
      pulseCnt <= '0;
    end else begin
      if (cmd.shift)    bitCnt   <= bitCnt + 1'b1;
      if (cmd.pulseInc) pulseCnt <= pulseCnt + 1'b1;
    end
  end

  // Settling delay
  always_ff @(posedge clk) begin
    if (!rstN || !cmd.settleRun) settleCnt <= '0;
    else                         settleCnt <= settleCnt + 1'b1;
  end

  assign phaseEnd  = (phaseCnt == halfLat - 1'b1);
  assign lastBit   = (bitCnt == BIT_W'(WORD_W - 1));
  assign lastPulse = (pulseCnt == PULSE_W'(BURN_PULSES - 1));
  assign settleEnd = (settleCnt == settleLat);
  assign dataBit   = wordReg[WORD_W-1];

  // R4: timebase stays inside the latched half period
  a_r4_phase_bound: assert property (@(posedge clk) disable iff (!rstN)
    phaseCnt < halfLat);

  // R9: settings move only on a load
  a_r9_settings_held: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.load |=> $stable(halfLat) && $stable(settleLat));

  // R2: word moves only by load or shift
  a_r2_word_held: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.load && !cmd.shift |=> $stable(wordReg));

endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
  import otp_prog_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    phaseEnd,
  input  logic    lastBit,
  input  logic    settleEnd,
  input  logic    lastPulse,
  input  logic    dataBit,
  output seqCmd_t cmd,
  output logic    csN,
  output logic    sClk,
  output logic    progData,
  output logic    vprogEn,
  output logic    busy,
  output logic    done
);

  seqState_t st, stNext;

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  always_comb begin
    stNext = st;
    cmd    = '0;
    unique case (st)
      ST_IDLE: begin
        if (start) begin
          cmd.load = 1'b1;
          stNext   = ST_PRE;
        end
      end
      ST_PRE: begin
        cmd.phaseRun = 1'b1;
        if (phaseEnd) stNext = ST_OPEN;
      end
      ST_OPEN: begin
        cmd.phaseRun = 1'b1;
        if (phaseEnd) stNext = ST_SLO;
      end
      ST_SLO: begin
        cmd.phaseRun = 1'b1;
        if (phaseEnd) stNext = ST_SHI;
      end
      ST_SHI: begin
        cmd.phaseRun = 1'b1;
        if (phaseEnd) begin
          if (lastBit) stNext = ST_SETTLE;
          else begin
            cmd.shift = 1'b1;
            stNext    = ST_SLO;
          end
        end
      end
      ST_SETTLE: begin
        cmd.settleRun = 1'b1;
        if (settleEnd) stNext = ST_BLO;
      end
      ST_BLO: begin
        cmd.phaseRun = 1'b1;
        if (phaseEnd) stNext = ST_BHI;
      end
      ST_BHI: begin
        cmd.phaseRun = 1'b1;
        if (phaseEnd) begin
          if (lastPulse) stNext = ST_DONE;
          else begin
            cmd.pulseInc = 1'b1;
            stNext       = ST_BLO;
          end
        end
      end
      ST_DONE: stNext = ST_DONE;
      default: stNext = ST_IDLE;
    endcase
  end

  // Output decode from state and word register only
  assign csN      = !(st == ST_IDLE || st == ST_PRE);
  assign sClk     = (st == ST_SHI) || (st == ST_BHI);
  assign progData = (st == ST_PRE || st == ST_OPEN) ? 1'b1 :
                    (st == ST_SLO || st == ST_SHI)  ? dataBit : 1'b0;
  assign vprogEn  = (st == ST_SETTLE) || (st == ST_BLO) || (st == ST_BHI);
  assign busy     = (st != ST_IDLE) && (st != ST_DONE);
  assign done     = (st == ST_DONE);

  // R4: data moves only with a falling clock during the shift
  a_r4_data_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    ((st == ST_SLO || st == ST_SHI) &&
     ($past(st) == ST_SLO || $past(st) == ST_SHI) &&
     !$stable(progData)) |-> $fell(sClk));

  // R3: select rises only with the program line high
  a_r3_open_with_prog: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> progData);

  // R5: never drive data while high voltage is on
  a_r5_no_data_on_hv: assert property (@(posedge clk) disable iff (!rstN)
    vprogEn |-> !progData);

  // R7: done is sticky and quiet
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done && !vprogEn && !sClk && csN);

  // R8: busy and done exclusive
  a_r8_busy_done: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busy, done}));

endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
  import otp_prog_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int SETTLE_W = 12,
  parameter int BURN_PULSES = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                cfgCcw,
  input  logic [ZERO_W-1:0]   cfgZero,
  input  logic                cfgGainInt,
  input  logic                cfgRefExt,
  input  logic                cfgClamp,
  input  logic [1:0]          cfgRange,
  input  logic [DIV_W-1:0]    halfPeriod,
  input  logic [SETTLE_W-1:0] settleCycles,
  output logic                csN,
  output logic                sClk,
  output logic                progData,
  output logic                vprogEn,
  output logic                busy,
  output logic                done
);

  seqCmd_t           cmd;
  logic              phaseEnd, lastBit, settleEnd, lastPulse, dataBit;
  logic [WORD_W-1:0] cfgWord;

  // R2: field placement, sent MSB first
  assign cfgWord = {cfgCcw, cfgZero, cfgGainInt, cfgRefExt, cfgClamp, cfgRange};

  otp_prog_dp #(
    .DIV_W(DIV_W), .SETTLE_W(SETTLE_W), .BURN_PULSES(BURN_PULSES)
  ) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .cfgWord(cfgWord),
    .halfPeriod(halfPeriod), .settleCycles(settleCycles),
    .phaseEnd(phaseEnd), .lastBit(lastBit), .settleEnd(settleEnd),
    .lastPulse(lastPulse), .dataBit(dataBit)
  );

  otp_prog_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start),
    .phaseEnd(phaseEnd), .lastBit(lastBit), .settleEnd(settleEnd),
    .lastPulse(lastPulse), .dataBit(dataBit), .cmd(cmd),
    .csN(csN), .sClk(sClk), .progData(progData), .vprogEn(vprogEn),
    .busy(busy), .done(done)
  );

endmodule

// File: tb/tb_otp_prog_seq.sv
module tb_otp_prog_seq;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       cfgCcw = 1'b0;
  logic [9:0] cfgZero = '0;
  logic       cfgGainInt = 1'b0, cfgRefExt = 1'b0, cfgClamp = 1'b0;
  logic [1:0] cfgRange = '0;
  logic [7:0] halfPeriod = '0;
  logic [11:0] settleCycles = '0;
  logic csN, sClk, progData, vprogEn, busy, done;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  otp_prog_seq dut (
    .clk(clk), .rstN(rstN), .start(start), .cfgCcw(cfgCcw), .cfgZero(cfgZero),
    .cfgGainInt(cfgGainInt), .cfgRefExt(cfgRefExt), .cfgClamp(cfgClamp),
    .cfgRange(cfgRange), .halfPeriod(halfPeriod), .settleCycles(settleCycles),
    .csN(csN), .sClk(sClk), .progData(progData), .vprogEn(vprogEn),
    .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic setWord(input logic [15:0] w);
    {cfgCcw, cfgZero, cfgGainInt, cfgRefExt, cfgClamp, cfgRange} = w;
  endtask

  task automatic check(input string req, input logic [5:0] got, input logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b (csN sClk prog vprog busy done)", req, got, exp);
    end
  endtask

  // Expected {csN,sClk,progData,vprogEn,busy,done} t cycles after start edge
  function automatic logic [5:0] model(input int t, input int h, input int s,
                                       input logic [15:0] w, output string req);
    int hh = (h == 0) ? 1 : h;
    int p;
    if (t < hh) begin
      req = "R3"; return 6'b001010;
    end else if (t < 2*hh) begin
      req = "R3"; return 6'b101010;
    end else if (t < 34*hh) begin
      p = (t - 2*hh) / hh;
      req = (p % 2 == 1) ? "R4" : "R2";
      return {1'b1, 1'(p % 2), w[15 - p/2], 3'b010};
    end else if (t < 34*hh + s + 1) begin
      req = "R5"; return 6'b100110;
    end else if (t < 66*hh + s + 1) begin
      p = (t - 34*hh - s - 1) / hh;
      req = "R6"; return {1'b1, 1'(p % 2), 4'b0110};
    end else begin
      req = (t == 66*hh + s + 1) ? "R8" : "R7";
      return 6'b100001;
    end
  endfunction

  task automatic runOne(input int h, input int s, input logic [15:0] w);
    int endT = 66*((h == 0) ? 1 : h) + s + 1;
    string req;
    logic [5:0] exp;
    @(negedge clk);
    rstN = 1'b0; start = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", {csN, sClk, progData, vprogEn, busy, done}, 6'b000000);
    setWord(w);
    halfPeriod = 8'(h);
    settleCycles = 12'(s);
    start = 1'b1;
    for (int t = 0; t < endT + 12; t++) begin
      @(negedge clk);
      start = 1'b0;
      exp = model(t, h, s, w, req);
      check(req, {csN, sClk, progData, vprogEn, busy, done}, exp);
      // R9: restart and input changes mid-run and after done
      if (t == 3 || t == endT + 3) begin
        start = 1'b1;
        setWord(~w);
        halfPeriod = 8'(h + 2);
        settleCycles = 12'(s + 4);
      end
    end
  endtask

  initial begin
    logic [15:0] pats [4];
    pats[0] = 16'hA5C3; pats[1] = 16'h0001; pats[2] = 16'h8000; pats[3] = 16'h6E19;
    for (int h = 0; h < 4; h++)
      for (int si = 0; si < 3; si++)
        for (int wi = 0; wi < 4; wi++)
          runOne(h, (si == 0) ? 0 : (si == 1) ? 2 : 7, pats[(wi + h) % 4]);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule